// File: doc/BRIEF.md
# Saturating Stereo Voice Mixer

This block takes the raw sample word (or words) of one voice for one output tick, expands it from one of four packed layouts into a right and a left 16-bit sample, scales each by its own 8-bit volume, and adds the results into two existing samples of a 16-bit stereo accumulation buffer. Sums are clamped to the signed 16-bit range. The mixed right value is produced first, then the left, so the caller can write them back to its buffer in that order.

One tick is taken per input handshake. The caller states whether a new source sample was fetched for this tick. When none was, the block mixes the scaled values kept from the last fetched tick again. This lets the voice play slower than the output rate without re-reading its source. Address generation and buffer storage belong to the caller.

Top module: `vmix_voice`

## Requirements
- R1: Format code 0 (8-bit mono): the byte taken from word 0 is bits 15:8 when `in_odd` is 0, and bits 7:0 when `in_odd` is 1. It becomes bits 15:8 of a 16-bit sample whose low byte is zero, and that sample feeds both channels.
- R2: Format code 1 (8-bit stereo): bits 15:8 of word 0 form the right sample and bits 7:0 form the left sample. Each is placed in bits 15:8 with a zero low byte.
- R3: Format code 2 (16-bit mono) feeds word 0 to both channels. Format code 3 (16-bit stereo) feeds word 0 to the right channel and word 1 to the left.
- R4: Each channel's scaled value is the signed sample times its unsigned volume (0 to 255), shifted arithmetically right by 8, which rounds toward negative infinity. A volume of 0 contributes exactly zero.
- R5: Each output equals the scaled value plus the sign-extended buffer sample of the same channel, clamped to the range -32768 to +32767.
- R6: The right result appears with `out_left`=0 on the cycle after the input is accepted. Once it has been taken, the left result follows with `out_left`=1.
- R7: While `out_valid` is high and `out_ready` is low, `out_sample` and `out_left` hold their values.
- R8: With `in_fetch`=0, the words, format, position bit and volumes of the tick are ignored, and the scaled values kept from the last fetched tick are mixed again. After reset the kept values are zero.
- R9: After reset `in_ready` is 1 and `out_valid` is 0. Input is accepted only while no pair is pending, and `in_ready` returns to 1 on the cycle after the left result is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Tick request |
| in_ready | output | 1 | Block can accept a tick |
| in_fmt | input | 2 | Source layout code |
| in_odd | input | 1 | Byte position within word 0 for 8-bit mono |
| in_fetch | input | 1 | A new source sample was fetched this tick |
| in_word0 | input | 16 | First source word |
| in_word1 | input | 16 | Second source word (16-bit stereo) |
| in_vol_r | input | 8 | Right volume |
| in_vol_l | input | 8 | Left volume |
| in_buf_r | input | 16 | Existing right buffer sample |
| in_buf_l | input | 16 | Existing left buffer sample |
| out_valid | output | 1 | Mixed result available |
| out_ready | input | 1 | Caller takes the result |
| out_left | output | 1 | 0 for the right result, 1 for the left |
| out_sample | output | 16 | Mixed, clamped sample |

## Verification
The assertions assume that the caller changes no tick inputs except across an accepted handshake. They also assume that `out_ready` matters only while `out_valid` is high, and that the clamped sum is checked against inputs captured on the accepting edge. The stimulus sets every input on the falling clock edge, keeps `in_valid` high for exactly one accepting edge, and stalls `out_ready` only on chosen ticks. This keeps every sweep inside those assumptions, while the volumes and buffer values still reach their extremes.

// File: rtl/vmix_pkg.sv
package vmix_pkg;
  localparam int SMP_W = 16;
  localparam int VOL_W = 8;
  localparam int HALF_W = SMP_W / 2;

  typedef enum logic [1:0] {
    FMT_MONO8    = 2'd0,
    FMT_STEREO8  = 2'd1,
    FMT_MONO16   = 2'd2,
    FMT_STEREO16 = 2'd3
  } vmix_fmt_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RIGHT = 2'd1,
    ST_LEFT  = 2'd2
  } vmix_state_e;

  typedef struct packed {
    logic signed [SMP_W-1:0] r;
    logic signed [SMP_W-1:0] l;
  } vmix_pair_t;

  // expand one packed source layout into a right/left pair
  function automatic vmix_pair_t expand(input logic [1:0] fmt, input logic odd,
                                        input logic [SMP_W-1:0] w0,
                                        input logic [SMP_W-1:0] w1);
    vmix_pair_t p;
    logic [HALF_W-1:0] b;
    b = odd ? w0[HALF_W-1:0] : w0[SMP_W-1:HALF_W];
    case (vmix_fmt_e'(fmt))
      FMT_MONO8: begin
        p.r = {b, {HALF_W{1'b0}}};
        p.l = {b, {HALF_W{1'b0}}};
      end
      FMT_STEREO8: begin
        p.r = {w0[SMP_W-1:HALF_W], {HALF_W{1'b0}}};
        p.l = {w0[HALF_W-1:0], {HALF_W{1'b0}}};
      end
      FMT_MONO16: begin
        p.r = w0;
        p.l = w0;
      end
      default: begin
        p.r = w0;
        p.l = w1;
      end
    endcase
    return p;
  endfunction

  // signed sample times unsigned volume, arithmetic shift right by VOL_W
  function automatic logic signed [SMP_W-1:0] scale(input logic signed [SMP_W-1:0] x,
                                                    input logic [VOL_W-1:0] vol);
    logic signed [SMP_W+VOL_W:0] prod;
    logic signed [SMP_W+VOL_W:0] shr;
    prod = x * $signed({1'b0, vol});
    shr  = prod >>> VOL_W;
    return shr[SMP_W-1:0];
  endfunction

  // add with clamping to the signed SMP_W range
  function automatic logic signed [SMP_W-1:0] sat_add(input logic signed [SMP_W-1:0] a,
                                                      input logic signed [SMP_W-1:0] b);
    logic signed [SMP_W:0] s;
    s = {a[SMP_W-1], a} + {b[SMP_W-1], b};
    if (s[SMP_W] != s[SMP_W-1])
      return s[SMP_W] ? {1'b1, {(SMP_W-1){1'b0}}} : {1'b0, {(SMP_W-1){1'b1}}};
    return s[SMP_W-1:0];
  endfunction
endpackage

// File: rtl/vmix_unpack.sv
module vmix_unpack
  import vmix_pkg::*;
#(
  parameter int W = SMP_W
) (
  input  logic [1:0]   fmt,
  input  logic         odd,
  input  logic [W-1:0] word0,
  input  logic [W-1:0] word1,
  output vmix_pair_t   pair
);
  always_comb pair = expand(fmt, odd, word0, word1);
endmodule

// File: rtl/vmix_scale.sv
module vmix_scale
  import vmix_pkg::*;
#(
  parameter int W  = SMP_W,
  parameter int VW = VOL_W
) (
  input  logic signed [W-1:0] raw,
  input  logic [VW-1:0]       vol,
  output logic signed [W-1:0] scaled
);
  always_comb scaled = scale(raw, vol);
endmodule

// File: rtl/vmix_clamp_add.sv
module vmix_clamp_add
  import vmix_pkg::*;
#(
  parameter int W = SMP_W
) (
  input  logic signed [W-1:0] contrib,
  input  logic signed [W-1:0] prior,
  output logic signed [W-1:0] mixed
);
  always_comb mixed = sat_add(contrib, prior);
endmodule

// File: rtl/vmix_voice.sv
module vmix_voice
  import vmix_pkg::*;
#(
  parameter int W  = SMP_W,
  parameter int VW = VOL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_fmt,
  input  logic          in_odd,
  input  logic          in_fetch,
  input  logic [W-1:0]  in_word0,
  input  logic [W-1:0]  in_word1,
  input  logic [VW-1:0] in_vol_r,
  input  logic [VW-1:0] in_vol_l,
  input  logic [W-1:0]  in_buf_r,
  input  logic [W-1:0]  in_buf_l,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_left,
  output logic [W-1:0]  out_sample
);
  localparam int NCH = 2;  // index 0 right, 1 left

  vmix_state_e st;
  vmix_pair_t  pair;

  logic signed [W-1:0] raw_ch    [NCH];
  logic        [VW-1:0] vol_ch   [NCH];
  logic signed [W-1:0] scl_ch    [NCH];
  logic signed [W-1:0] held_ch   [NCH];
  logic signed [W-1:0] prior_ch  [NCH];

  // named events
  logic accept, emit, pair_done;
  logic signed [W-1:0] sel_held, sel_prior, mixed;

  assign in_ready  = (st == ST_IDLE);
  assign out_valid = (st != ST_IDLE);
  assign out_left  = (st == ST_LEFT);
  assign accept    = in_valid && in_ready;
  assign emit      = out_valid && out_ready;
  assign pair_done = emit && out_left;

  vmix_unpack #(.W(W)) u_unpack (
    .fmt(in_fmt), .odd(in_odd), .word0(in_word0), .word1(in_word1), .pair(pair)
  );

  assign raw_ch[0] = pair.r;
  assign raw_ch[1] = pair.l;
  assign vol_ch[0] = in_vol_r;
  assign vol_ch[1] = in_vol_l;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    vmix_scale #(.W(W), .VW(VW)) u_scale (
      .raw(raw_ch[c]), .vol(vol_ch[c]), .scaled(scl_ch[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_IDLE;
      for (int c = 0; c < NCH; c++) begin
        held_ch[c]  <= '0;
        prior_ch[c] <= '0;
      end
    end else begin
      case (st)
        ST_IDLE:  if (accept) st <= ST_RIGHT;
        ST_RIGHT: if (emit) st <= ST_LEFT;
        ST_LEFT:  if (emit) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
      if (accept) begin
        prior_ch[0] <= in_buf_r;
        prior_ch[1] <= in_buf_l;
        if (in_fetch) begin
          for (int c = 0; c < NCH; c++) held_ch[c] <= scl_ch[c];
        end
      end
    end
  end

  assign sel_held  = out_left ? held_ch[1]  : held_ch[0];
  assign sel_prior = out_left ? prior_ch[1] : prior_ch[0];

  vmix_clamp_add #(.W(W)) u_mix (
    .contrib(sel_held), .prior(sel_prior), .mixed(mixed)
  );

  assign out_sample = mixed;
endmodule

// File: rtl/vmix_voice_chk.sv
module vmix_voice_chk #(
  parameter int W  = 16,
  parameter int VW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          in_fetch,
  input logic [VW-1:0] in_vol_r,
  input logic [W-1:0]  in_buf_r,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_left,
  input logic [W-1:0]  out_sample,
  input logic          accept,
  input logic          emit
);
  // R6: right result follows acceptance by one cycle
  a_r6_accept_to_right: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid && !out_left);

  // R6: left follows a taken right result
  a_r6_right_then_left: assert property (@(posedge clk) disable iff (!rst_n)
    emit && !out_left |=> out_valid && out_left);

  // R9: ready again once the left result is taken
  a_r9_left_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    emit && out_left |=> in_ready && !out_valid);

  // R7: output held under back-pressure
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_left) && $stable(out_sample));

  // R4: zero right volume passes the right buffer sample through
  a_r4_zero_vol: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_fetch && (in_vol_r == '0) |=> out_sample == $past(in_buf_r));
endmodule

bind vmix_voice vmix_voice_chk #(.W(W), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .in_fetch(in_fetch),
  .in_vol_r(in_vol_r), .in_buf_r(in_buf_r), .out_valid(out_valid),
  .out_ready(out_ready), .out_left(out_left), .out_sample(out_sample),
  .accept(accept), .emit(emit)
);

// File: tb/vmix_voice_tb.sv
`timescale 1ns/1ps
module vmix_voice_tb;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [1:0] in_fmt = 0;
  logic in_odd = 0, in_fetch = 0;
  logic [15:0] in_word0 = 0, in_word1 = 0, in_buf_r = 0, in_buf_l = 0;
  logic [7:0] in_vol_r = 0, in_vol_l = 0;
  logic out_valid, out_ready = 0, out_left;
  logic [15:0] out_sample;

  int n_chk = 0, n_bad = 0;
  int prev_r = 0, prev_l = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  vmix_voice u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int floor_div256(input int p);
    int q;
    q = p / 256;
    if (p < 0 && q * 256 != p) q = q - 1;
    return q;
  endfunction

  function automatic int clamp16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int s16(input logic [15:0] w);
    return (w >= 16'h8000) ? int'(w) - 65536 : int'(w);
  endfunction

  function automatic int s8hi(input logic [7:0] b);
    return ((b >= 8'h80) ? int'(b) - 256 : int'(b)) * 256;
  endfunction

  task automatic tick(input string req, input logic [1:0] f, input logic odd,
                      input logic fe, input logic [15:0] w0, input logic [15:0] w1,
                      input logic [7:0] vr, input logic [7:0] vl,
                      input logic [15:0] br, input logic [15:0] bl, input int stall,
                      output logic [15:0] got_r, output logic [15:0] got_l);
    int sr, sl, er, el;
    if (fe) begin
      case (f)
        2'd0: begin sr = s8hi(odd ? w0[7:0] : w0[15:8]); sl = sr; end
        2'd1: begin sr = s8hi(w0[15:8]); sl = s8hi(w0[7:0]); end
        2'd2: begin sr = s16(w0); sl = sr; end
        default: begin sr = s16(w0); sl = s16(w1); end
      endcase
      prev_r = floor_div256(sr * int'(vr));
      prev_l = floor_div256(sl * int'(vl));
    end
    er = clamp16(prev_r + s16(br));
    el = clamp16(prev_l + s16(bl));
    in_fmt = f; in_odd = odd; in_fetch = fe; in_word0 = w0; in_word1 = w1;
    in_vol_r = vr; in_vol_l = vl; in_buf_r = br; in_buf_l = bl;
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    in_word0 = ~w0; in_vol_r = ~vr; in_buf_r = ~br;
    chk({req, "/R6 right first"}, {out_valid, out_left}, 2);
    chk(req, s16(out_sample), er);
    got_r = out_sample;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R7 hold", {out_valid, out_left}, 2);
      chk("R7 hold value", s16(out_sample), er);
    end
    out_ready = 1;
    @(negedge clk);
    chk({req, "/R6 left second"}, {out_valid, out_left}, 3);
    chk(req, s16(out_sample), el);
    got_l = out_sample;
    @(negedge clk);
    out_ready = 0;
    chk("R9 ready after pair", {in_ready, out_valid}, 2);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] gr, gl;
    logic [15:0] words [8] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF,
                               16'h1234, 16'h80FF, 16'h7F01, 16'hC3A5};
    logic [15:0] bufs [5] = '{16'h0000, 16'h7FFF, 16'h8000, 16'h1000, 16'hF000};
    logic [7:0] vols [6] = '{8'd0, 8'd1, 8'd127, 8'd128, 8'd254, 8'd255};
    logic [15:0] mem [2];

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset state", {in_ready, out_valid}, 2);

    // R8: no fetch right after reset mixes zero contributions
    tick("R8 reset hold", 2'd3, 0, 0, 16'h7FFF, 16'h7FFF, 8'hFF, 8'hFF,
         16'h1111, 16'hEEEE, 0, gr, gl);

    // sweep formats, positions, volumes, words, buffers (R1, R2, R3, R4, R5)
    for (int f = 0; f < 4; f++)
      for (int o = 0; o < 2; o++)
        for (int v = 0; v < 6; v++)
          for (int w = 0; w < 8; w++)
            for (int b = 0; b < 5; b++) begin
              string req;
              case (f)
                0: req = "R1 mono8";
                1: req = "R2 stereo8";
                default: req = "R3 16bit";
              endcase
              tick(req, 2'(f), 1'(o), 1, words[w], words[7 - w], vols[v], vols[5 - v],
                   bufs[b], bufs[4 - b], ((w + b) % 7 == 0) ? 2 : 0, gr, gl);
            end

    // R4: full-scale and floor rounding spot checks
    tick("R4 floor", 2'd3, 0, 1, 16'hFFFF, 16'h8000, 8'd255, 8'd255,
         16'h0000, 16'h0000, 0, gr, gl);
    chk("R4 neg one floors", s16(gr), -1);
    chk("R4 min times 255", s16(gl), -32640);

    // R8: fetch=0 ignores new words and volumes
    tick("R8 fetch", 2'd2, 0, 1, 16'h4000, 16'h0, 8'd128, 8'd64,
         16'h0, 16'h0, 0, gr, gl);
    tick("R8 reuse", 2'd1, 1, 0, 16'h8080, 16'h1234, 8'd3, 8'd200,
         16'h0100, 16'hFF00, 1, gr, gl);
    chk("R8 reuse right", s16(gr), 8192 + 256);
    chk("R8 reuse left", s16(gl), 4096 - 256);

    // R5: accumulate into a two-word buffer until both ends clamp
    mem[0] = 16'h0; mem[1] = 16'h0;
    for (int k = 0; k < 8; k++) begin
      tick("R5 accumulate", 2'd3, 0, 1, 16'h7000, 16'h9000, 8'd255, 8'd255,
           mem[0], mem[1], 0, gr, gl);
      mem[0] = gr; mem[1] = gl;
    end
    chk("R5 clamp high", s16(mem[0]), 32767);
    chk("R5 clamp low", s16(mem[1]), -32768);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule